// File: doc/BRIEF.md
# Full-Frame CCD Readout Clock Sequencer

This block produces the digital timing for a two-phase full-frame CCD with a single output amplifier. A frame start request begins one frame. The frame is a programmable integration period, followed by readout of every line. Each line has three parts, in this order:

- a three-slot vertical transfer that drops one row into the horizontal register;
- a horizontal setup gap;
- horizontal shifting of every pixel, plus one extra flush period.

While the horizontal register shifts, the block pulses the reset gate once in every pixel period. It also emits a one-cycle sample strobe for an external converter. The strobe carries the pixel and line number of the packet being presented.

All durations are parameters counted in system clock cycles. The block is told the clock period in nanoseconds. At elaboration it rejects settings that fall below the sensor's minimums:

| Timing | Minimum |
|---|---|
| Vertical phase width | 1.5 µs |
| Horizontal setup | 0.5 µs |
| Pixel period | 100 ns (10 MHz horizontal rate) |
| Reset pulse | 10 ns |

It also rejects an odd pixel period, and a reset pulse that does not fit inside half a pixel period. Level shifting, clock drivers and the converter stay outside the block.

Top module: `ccd_readout_seq`

## Requirements
- R1: After reset, and whenever no frame is in progress, the outputs rest as follows: busy=0, v1=0, v2=0, h1=1, h2=0, rst_gate=0, smp_strobe=0.
- R2: A frame_start sampled high while idle makes busy rise at the next clock edge. Integration then lasts int_len cycles, where 0 acts as 1. Throughout integration v1 and v2 are both low and h1 is held high.
- R3: A frame_start sampled while busy is ignored. The frame in progress keeps its timing, and no new frame follows it.
- R4: Each line opens with v1 high for V_W cycles. Then v2 is high for 2*V_W cycles. v2 falls while h1 is high and v1 is low.
- R5: After the v2 falling edge comes a setup gap of HS_W cycles, with h1=1 and h2=0.
- R6: The horizontal phase is PIXELS+1 periods of PIX_W cycles each. In each period h2 is high for the first PIX_W/2 cycles and h1 for the last PIX_W/2, so the two are always complementary.
- R7: In every horizontal period, rst_gate is high for RST_W cycles, starting in the cycle where h2 falls.
- R8: smp_strobe is a one-cycle pulse RST_W cycles after each h2 fall, in the first PIXELS periods of a line only. It carries smp_pix = period number (1..PIXELS) and smp_line = line number (1..LINES). A frame yields exactly LINES*PIXELS strobes.
- R9: A frame is LINES lines of 3*V_W + HS_W + (PIXELS+1)*PIX_W cycles each. busy falls exactly int_len (0 acts as 1) plus LINES line times after it rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | Frame request, sampled on each rising edge |
| int_len | input | INT_W | Integration length in clock cycles |
| busy | output | 1 | High from integration start to the end of the last line |
| v1 | output | 1 | Vertical phase 1 clock |
| v2 | output | 1 | Vertical phase 2 clock |
| h1 | output | 1 | Horizontal phase 1 clock |
| h2 | output | 1 | Horizontal phase 2 clock |
| rst_gate | output | 1 | Sense-node reset clock |
| smp_strobe | output | 1 | One-cycle converter sample request |
| smp_pix | output | PIX_IDX_W | Pixel number presented with the strobe |
| smp_line | output | LINE_IDX_W | Line number presented with the strobe |

## Verification
Assertions check the following on every cycle:

- the resting levels whenever the block is idle;
- that v2 only falls while h1 is high;
- that every reset pulse begins on an h2 fall;
- that each strobe is a single cycle directly after a reset pulse;
- that no frame restarts once readout has begun;
- that the line and pixel counters stay in range.

Exact durations can only be shown by the bench's scenarios. These are the integration length including the zero case, the vertical slot widths, the setup gap, the pixel phase positions, the strobe indices and their count, and the cycle in which busy falls. So can the rejection of start requests made in the middle of a frame.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_INTEG  = 3'd1,
    ST_VXFER  = 3'd2,
    ST_SETUP  = 3'd3,
    ST_HSHIFT = 3'd4
  } seq_state_e;
endpackage

// File: rtl/ccdseq_fsm.sv
module ccdseq_fsm
  import ccdseq_pkg::*;
#(
  parameter int INT_W      = 24,
  parameter int V_W        = 200,
  parameter int HS_W       = 100,
  parameter int PIX_W      = 26,
  parameter int LINES      = 520,
  parameter int PIXELS     = 796,
  parameter int PIX_IDX_W  = 10,
  parameter int LINE_IDX_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [INT_W-1:0]      int_len,
  output seq_state_e            state_o,
  output logic [INT_W-1:0]      tcnt_o,
  output logic [1:0]            slot_o,
  output logic [PIX_IDX_W-1:0]  pix_o,
  output logic [LINE_IDX_W-1:0] line_o
);
  localparam logic [INT_W-1:0]      V_LAST    = INT_W'(V_W - 1);
  localparam logic [INT_W-1:0]      HS_LAST   = INT_W'(HS_W - 1);
  localparam logic [INT_W-1:0]      PIX_LAST  = INT_W'(PIX_W - 1);
  localparam logic [PIX_IDX_W-1:0]  PIX_END   = PIX_IDX_W'(PIXELS);
  localparam logic [LINE_IDX_W-1:0] LINE_LAST = LINE_IDX_W'(LINES - 1);

  seq_state_e            state_q, state_d;
  logic [INT_W-1:0]      tcnt_q, tcnt_d;
  logic [1:0]            slot_q, slot_d;
  logic [PIX_IDX_W-1:0]  pix_q, pix_d;
  logic [LINE_IDX_W-1:0] line_q, line_d;
  logic                  run_en;
  logic                  int_done;

  assign int_done = ({1'b0, tcnt_q} + (INT_W+1)'(1)) >= {1'b0, int_len};
  assign run_en   = (state_q != ST_IDLE) || start;

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q + INT_W'(1);
    slot_d  = slot_q;
    pix_d   = pix_q;
    line_d  = line_q;
    case (state_q)
      ST_IDLE: begin
        tcnt_d = '0;
        if (start) state_d = ST_INTEG;
      end
      ST_INTEG: begin
        if (int_done) begin
          state_d = ST_VXFER;
          tcnt_d  = '0;
          slot_d  = '0;
          line_d  = '0;
        end
      end
      ST_VXFER: begin
        if (tcnt_q == V_LAST) begin
          tcnt_d = '0;
          if (slot_q == 2'd2) state_d = ST_SETUP;
          else                slot_d  = slot_q + 2'd1;
        end
      end
      ST_SETUP: begin
        if (tcnt_q == HS_LAST) begin
          state_d = ST_HSHIFT;
          tcnt_d  = '0;
          pix_d   = '0;
        end
      end
      ST_HSHIFT: begin
        if (tcnt_q == PIX_LAST) begin
          tcnt_d = '0;
          if (pix_q == PIX_END) begin
            pix_d = '0;
            if (line_q == LINE_LAST) begin
              state_d = ST_IDLE;
            end else begin
              line_d  = line_q + LINE_IDX_W'(1);
              slot_d  = '0;
              state_d = ST_VXFER;
            end
          end else begin
            pix_d = pix_q + PIX_IDX_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      slot_q  <= '0;
      pix_q   <= '0;
      line_q  <= '0;
    end else if (run_en) begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      slot_q  <= slot_d;
      pix_q   <= pix_d;
      line_q  <= line_d;
    end
  end

  assign state_o = state_q;
  assign tcnt_o  = tcnt_q;
  assign slot_o  = slot_q;
  assign pix_o   = pix_q;
  assign line_o  = line_q;

  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_INTEG) |=> (state_q != ST_INTEG));

  assert_pix_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HSHIFT) |-> (pix_q <= PIX_END));

  assert_line_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (line_q <= LINE_LAST));
endmodule

// File: rtl/ccdseq_wave.sv
module ccdseq_wave
  import ccdseq_pkg::*;
#(
  parameter int INT_W      = 24,
  parameter int PIX_W      = 26,
  parameter int RST_W      = 2,
  parameter int PIXELS     = 796,
  parameter int PIX_IDX_W  = 10,
  parameter int LINE_IDX_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  seq_state_e            state,
  input  logic [INT_W-1:0]      tcnt,
  input  logic [1:0]            slot,
  input  logic [PIX_IDX_W-1:0]  pix,
  input  logic [LINE_IDX_W-1:0] line,
  output logic                  busy,
  output logic                  v1,
  output logic                  v2,
  output logic                  h1,
  output logic                  h2,
  output logic                  rst_gate,
  output logic                  smp_strobe,
  output logic [PIX_IDX_W-1:0]  smp_pix,
  output logic [LINE_IDX_W-1:0] smp_line
);
  localparam logic [INT_W-1:0]     HALF_C  = INT_W'(PIX_W / 2);
  localparam logic [INT_W-1:0]     RST_END = INT_W'(PIX_W / 2 + RST_W);
  localparam logic [PIX_IDX_W-1:0] PIX_END = PIX_IDX_W'(PIXELS);

  logic in_h;

  always_comb begin
    in_h       = (state == ST_HSHIFT);
    busy       = (state != ST_IDLE);
    v1         = (state == ST_VXFER) && (slot == 2'd0);
    v2         = (state == ST_VXFER) && (slot != 2'd0);
    h2         = in_h && (tcnt < HALF_C);
    h1         = !h2;
    rst_gate   = in_h && (tcnt >= HALF_C) && (tcnt < RST_END);
    smp_strobe = in_h && (pix < PIX_END) && (tcnt == RST_END);
    smp_pix    = pix + PIX_IDX_W'(1);
    smp_line   = line + LINE_IDX_W'(1);
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!v1 && !v2 && h1 && !h2 && !rst_gate && !smp_strobe));

  assert_v2_fall_h1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(v2) |-> (h1 && !h2 && !v1));

  assert_rst_on_h2fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_gate) |-> $fell(h2));

  assert_strobe_after_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe |-> ($past(rst_gate) && !rst_gate));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe |=> !smp_strobe);
endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
  import ccdseq_pkg::*;
#(
  parameter int CLK_NS      = 10,
  parameter int INT_W       = 24,
  parameter int V_W         = 200,
  parameter int HS_W        = 100,
  parameter int PIX_W       = 26,
  parameter int RST_W       = 2,
  parameter int LINES       = 520,
  parameter int PIXELS      = 796,
  localparam int PIX_IDX_W  = $clog2(PIXELS + 1),
  localparam int LINE_IDX_W = $clog2(LINES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic [INT_W-1:0]      int_len,
  output logic                  busy,
  output logic                  v1,
  output logic                  v2,
  output logic                  h1,
  output logic                  h2,
  output logic                  rst_gate,
  output logic                  smp_strobe,
  output logic [PIX_IDX_W-1:0]  smp_pix,
  output logic [LINE_IDX_W-1:0] smp_line
);
  initial begin
    assert_v_width_min: assert (V_W * CLK_NS >= 1500)
      else $error("vertical phase width below 1.5 us");
    assert_setup_min: assert (HS_W * CLK_NS >= 500)
      else $error("horizontal setup below 0.5 us");
    assert_pix_min: assert (PIX_W * CLK_NS >= 100 && PIX_W % 2 == 0)
      else $error("pixel period below 100 ns or odd");
    assert_rst_fit: assert (RST_W * CLK_NS >= 10 && RST_W >= 1 && RST_W < PIX_W / 2)
      else $error("reset pulse too short or does not fit half a pixel");
  end

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  seq_state_e            st;
  logic [INT_W-1:0]      tcnt;
  logic [1:0]            slot;
  logic [PIX_IDX_W-1:0]  pix;
  logic [LINE_IDX_W-1:0] line;

  ccdseq_fsm #(
    .INT_W(INT_W), .V_W(V_W), .HS_W(HS_W), .PIX_W(PIX_W),
    .LINES(LINES), .PIXELS(PIXELS),
    .PIX_IDX_W(PIX_IDX_W), .LINE_IDX_W(LINE_IDX_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_sync_q), .start(frame_start), .int_len(int_len),
    .state_o(st), .tcnt_o(tcnt), .slot_o(slot), .pix_o(pix), .line_o(line)
  );

  ccdseq_wave #(
    .INT_W(INT_W), .PIX_W(PIX_W), .RST_W(RST_W), .PIXELS(PIXELS),
    .PIX_IDX_W(PIX_IDX_W), .LINE_IDX_W(LINE_IDX_W)
  ) u_wave (
    .clk(clk), .rst_n(rst_sync_q), .state(st), .tcnt(tcnt), .slot(slot),
    .pix(pix), .line(line),
    .busy(busy), .v1(v1), .v2(v2), .h1(h1), .h2(h2), .rst_gate(rst_gate),
    .smp_strobe(smp_strobe), .smp_pix(smp_pix), .smp_line(smp_line)
  );
endmodule

// File: tb/ccd_readout_seq_bench.sv
module ccd_readout_seq_bench;
  localparam int CLK_P  = 10;
  localparam int V_W    = 2;
  localparam int HS_W   = 1;
  localparam int PIX_W  = 4;
  localparam int RST_W  = 1;
  localparam int LINES  = 3;
  localparam int PIXELS = 4;
  localparam int INT_W  = 8;
  localparam int HALF   = PIX_W / 2;
  localparam int LT     = 3 * V_W + HS_W + (PIXELS + 1) * PIX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [INT_W-1:0] int_len = '0;
  logic busy, v1, v2, h1, h2, rst_gate, smp_strobe;
  logic [2:0] smp_pix;
  logic [1:0] smp_line;

  int n_tests = 0;
  int n_fail  = 0;
  int n_strobe;

  always #(CLK_P / 2) clk = ~clk;

  ccd_readout_seq #(
    .CLK_NS(1000), .INT_W(INT_W), .V_W(V_W), .HS_W(HS_W), .PIX_W(PIX_W),
    .RST_W(RST_W), .LINES(LINES), .PIXELS(PIXELS)
  ) u_ccd_readout_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .int_len(int_len),
    .busy(busy), .v1(v1), .v2(v2), .h1(h1), .h2(h2), .rst_gate(rst_gate),
    .smp_strobe(smp_strobe), .smp_pix(smp_pix), .smp_line(smp_line)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    chk(tag, "busy", busy, 0);
    chk(tag, "v1", v1, 0);
    chk(tag, "v2", v2, 0);
    chk(tag, "h1", h1, 1);
    chk(tag, "h2", h2, 0);
    chk(tag, "rst_gate", rst_gate, 0);
    chk(tag, "strobe", smp_strobe, 0);
  endtask

  // Arithmetic model of the frame: cycle c counted from the first cycle busy is high.
  task automatic check_cycle(input int c, input int eff, input int total, input bit poke);
    int e_busy = (c < total) ? 1 : 0;
    int ev1 = 0, ev2 = 0, eh1 = 1, eh2 = 0, erg = 0, est = 0, epix = 0, eline = 0;
    string tv = "R4";
    string th = "R6";
    if (c < eff) begin
      tv = "R2";
      th = "R2";
    end else if (c < total) begin
      int d = c - eff;
      int ln = d / LT;
      int r = d % LT;
      if (r < V_W) ev1 = 1;
      else if (r < 3 * V_W) ev2 = 1;
      else if (r < 3 * V_W + HS_W) th = "R5";
      else begin
        int q = r - 3 * V_W - HS_W;
        int j = q / PIX_W;
        int p = q % PIX_W;
        eh2 = (p < HALF) ? 1 : 0;
        eh1 = 1 - eh2;
        erg = (p >= HALF && p < HALF + RST_W) ? 1 : 0;
        est = (j < PIXELS && p == HALF + RST_W) ? 1 : 0;
        epix = j + 1;
        eline = ln + 1;
      end
    end
    chk(poke ? "R3" : ((c < eff) ? "R2" : "R9"), "busy", busy, e_busy);
    chk(tv, "v1", v1, ev1);
    chk(tv, "v2", v2, ev2);
    chk(th, "h1", h1, eh1);
    chk(th, "h2", h2, eh2);
    chk("R7", "rst_gate", rst_gate, erg);
    chk("R8", "strobe", smp_strobe, est);
    if (est == 1 && smp_strobe) begin
      chk("R8", "smp_pix", smp_pix, epix);
      chk("R8", "smp_line", smp_line, eline);
    end
    if (smp_strobe) n_strobe++;
  endtask

  task automatic run_frame(input int il, input bit poke);
    int eff = (il == 0) ? 1 : il;
    int total = eff + LINES * LT;
    int_len = INT_W'(il);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    n_strobe = 0;
    for (int c = 0; c <= total; c++) begin
      check_cycle(c, eff, total, poke);
      frame_start = (poke && c < total && (c % 7 == 3)) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    frame_start = 1'b0;
    chk("R8", "strobe count", n_strobe, LINES * PIXELS);
    // R3/R1: after the frame, nothing restarted
    for (int k = 0; k < 3; k++) begin
      check_idle(poke ? "R3" : "R1");
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1");
    run_frame(0, 1'b0);
    run_frame(1, 1'b0);
    run_frame(5, 1'b1);
    run_frame(13, 1'b0);
    run_frame(2, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule